// File: doc/BRIEF.md
# Key-Guarded Configuration Register Bank

This block holds a small bank of configuration words behind a simple synchronous register bus. Some of the words are guarded: a write to them lands only if the bus has first unlocked them with a secret key. The words themselves drive the `cfg_out` port, so the parts of the chip they control see a new value one clock after an accepted write.

There are two guarding schemes.

**Lock slot.** Each slot pairs one lock address with one configuration word and one key. Writing the right key opens the slot for a short window of `RELOCK_WIN` cycles. The first write to the guarded word inside that window lands and closes the slot. The slot also closes in these cases:
- the window runs out;
- the lock register is written with any value other than its key;
- the bus touches any address other than the slot's lock or target.

**Kick pair.** Two kick registers must both hold their own keys. While they do, every kick-protected word accepts writes. Clearing either kick register shuts the protection again.

Any word with neither guard is written directly. A write that is refused leaves the word unchanged and raises `wr_err` for one cycle. Reads are never blocked. Lock and kick registers always read back zero.

**Lock slot FSM.** There is one per slot. The states are `SLOT_SHUT` and `SLOT_OPEN`.
- `SHUT→OPEN` (arm): a key write to the lock address.
- `OPEN→OPEN` (re-arm): the key is written again, and the window restarts.
- `OPEN→OPEN` (tick): an idle cycle, or a read of the lock or target, and the window counts down.
- `OPEN→SHUT` happens on any of:
  - consume: a write to the target;
  - relock: any other value written to the lock;
  - cancel: an access to another address;
  - expire: the last window cycle passes unused.

**Kick FSM.** The states are `KICK_SHUT`, `KICK_HALF_A`, `KICK_HALF_B` and `KICK_OPEN`. Each write to a kick register sets or clears that register's half: it is set when the value equals that register's key and cleared otherwise. The FSM then moves to the state that names the halves now held. Only `KICK_OPEN` grants writes.

**Address map (word addresses).**
- Configuration word j is at address j, for j from 0 to 7.
- Lock slot i is at address 0x10+i, for i from 0 to 3. It guards word i and its key is 0x5EC01000+i.
- The kick registers are at 0x18 (key 0xC0DE0A11) and 0x19 (key 0x0B5E55ED). They protect words 4 and 5.
- Words 6 and 7 are unguarded.
- A lock slot takes precedence over kick protection.

Top module: `krw_key_bank`

## Requirements
- R1: After reset all configuration words are zero, `wr_err` is low and all lock slots and the kick pair are shut.
- R2: Writing key 0x5EC01000+i to address 0x10+i opens slot i. A write to word i on any of the next 4 cycles, with the bus otherwise idle, updates word i.
- R3: A write to word i arriving on the 5th cycle or later after the key write is dropped.
- R4: An accepted write consumes the unlock. A second write to the same word needs a fresh key.
- R5: Writing zero or any wrong value to a lock register leaves its slot shut, or shuts it if it was open.
- R6: A read or write to any address other than the slot's lock and target cancels an open slot.
- R7: Words 4 and 5 accept writes only while 0x18 holds 0xC0DE0A11 and 0x19 holds 0x0B5E55ED. One key alone is not enough.
- R8: Writing zero to either kick register shuts the kick pair again.
- R9: Words 6 and 7 are written directly with no key.
- R10: A dropped write leaves the word unchanged and raises `wr_err` for exactly the cycle after it. Accepted writes and writes to lock or kick registers do not raise `wr_err`.
- R11: A read returns configuration word j at address j whether or not it is locked. Lock and kick addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; counts as an access for slot cancelling |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| wr_err | output | 1 | One-cycle pulse after a dropped write |
| cfg_out | output | N_CFG*DATA_W | All configuration words, word j at bits j*DATA_W upward |

## Verification
A slot stuck open, or an expiry counter off by one, shows up as a write landing on the 5th cycle or a refused write on the 4th. Either way, `wr_err` or a read-back of the word exposes it on the very next cycle. A kick FSM that opens on a single half lets a write to word 4 land: `cfg_out` changes and `wr_err` stays low one cycle later. A missed cancel shows up as a write accepted after an intervening read. Every wrong verdict therefore becomes visible one cycle after the offending write, through either `wr_err` or a read of the affected word.

// File: rtl/krw_pkg.sv
package krw_pkg;

    typedef enum logic [0:0] {
        SLOT_SHUT = 1'b0,
        SLOT_OPEN = 1'b1
    } slot_state_e;

    typedef enum logic [1:0] {
        KICK_SHUT   = 2'b00,
        KICK_HALF_A = 2'b01,
        KICK_HALF_B = 2'b10,
        KICK_OPEN   = 2'b11
    } kick_state_e;

    localparam logic [31:0] DFLT_SLOT_KEY_BASE = 32'h5EC0_1000;
    localparam logic [31:0] DFLT_KICK_KEY0     = 32'hC0DE_0A11;
    localparam logic [31:0] DFLT_KICK_KEY1     = 32'h0B5E_55ED;

endpackage

// File: rtl/krw_lock_slot.sv
module krw_lock_slot
    import krw_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          LOCK_ADDR = 16,
    parameter int          TGT_ADDR  = 0,
    parameter logic [DATA_W-1:0] KEY = '1,
    parameter int          WIN       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              slot_open
);
    localparam int CNT_W = $clog2(WIN + 1);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic at_lock, at_tgt, lock_wr, key_ok, tgt_wr, touch_other;

    always_comb begin
        at_lock     = (bus_addr == ADDR_W'(LOCK_ADDR));
        at_tgt      = (bus_addr == ADDR_W'(TGT_ADDR));
        lock_wr     = bus_wr && at_lock;
        key_ok      = (bus_wdata == KEY);
        tgt_wr      = bus_wr && at_tgt;
        touch_other = (bus_wr || bus_rd) && !at_lock && !at_tgt;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_SHUT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SLOT_SHUT: begin
                if (lock_wr && key_ok) begin      // arm
                    state_d = SLOT_OPEN;
                    cnt_d   = CNT_W'(WIN);
                end
            end
            SLOT_OPEN: begin
                if (lock_wr) begin
                    if (key_ok) begin             // re-arm
                        cnt_d = CNT_W'(WIN);
                    end else begin                // relock
                        state_d = SLOT_SHUT;
                        cnt_d   = '0;
                    end
                end else if (tgt_wr || touch_other) begin  // consume / cancel
                    state_d = SLOT_SHUT;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(1)) begin      // expire
                    state_d = SLOT_SHUT;
                    cnt_d   = '0;
                end else begin                    // tick
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = SLOT_SHUT;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        slot_open = (state_q == SLOT_OPEN);
    end

endmodule

// File: rtl/krw_kick_fsm.sv
module krw_kick_fsm
    import krw_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 32,
    parameter int                ADDR_A = 24,
    parameter int                ADDR_B = 25,
    parameter logic [DATA_W-1:0] KEY_A  = '1,
    parameter logic [DATA_W-1:0] KEY_B  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic              kick_open
);
    kick_state_e state_q, state_d;
    logic held_a, held_b, next_a, next_b;
    logic wr_a, wr_b;

    always_comb begin
        wr_a = bus_wr && (bus_addr == ADDR_W'(ADDR_A));
        wr_b = bus_wr && (bus_addr == ADDR_W'(ADDR_B));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KICK_SHUT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        held_a = 1'b0;
        held_b = 1'b0;
        unique case (state_q)
            KICK_SHUT:   begin held_a = 1'b0; held_b = 1'b0; end
            KICK_HALF_A: begin held_a = 1'b1; held_b = 1'b0; end
            KICK_HALF_B: begin held_a = 1'b0; held_b = 1'b1; end
            KICK_OPEN:   begin held_a = 1'b1; held_b = 1'b1; end
            default:     begin held_a = 1'b0; held_b = 1'b0; end
        endcase
        next_a = wr_a ? (bus_wdata == KEY_A) : held_a;
        next_b = wr_b ? (bus_wdata == KEY_B) : held_b;
        unique case ({next_b, next_a})
            2'b00:   state_d = KICK_SHUT;
            2'b01:   state_d = KICK_HALF_A;
            2'b10:   state_d = KICK_HALF_B;
            2'b11:   state_d = KICK_OPEN;
            default: state_d = KICK_SHUT;
        endcase
    end

    // outputs
    always_comb begin
        kick_open = (state_q == KICK_OPEN);
    end

endmodule

// File: rtl/krw_cfg_bank.sv
module krw_cfg_bank #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter int                N_CFG     = 8,
    parameter int                N_SLOT    = 4,
    parameter logic [N_CFG-1:0]  KICK_MASK = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_wr,
    input  logic [N_SLOT-1:0]       slot_open,
    input  logic                    kick_open,
    output logic [N_CFG*DATA_W-1:0] cfg_flat,
    output logic [DATA_W-1:0]       rd_word,
    output logic                    wr_drop
);
    logic [N_CFG-1:0][DATA_W-1:0] cfg_q;
    logic [N_CFG-1:0] hit, allow;

    for (genvar j = 0; j < N_CFG; j++) begin : g_word
        assign hit[j] = bus_wr && (bus_addr == ADDR_W'(j));
        if (j < N_SLOT) begin : g_slot_guard
            assign allow[j] = slot_open[j];
        end else if (KICK_MASK[j]) begin : g_kick_guard
            assign allow[j] = kick_open;
        end else begin : g_free
            assign allow[j] = 1'b1;
        end
        assign cfg_flat[j*DATA_W +: DATA_W] = cfg_q[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            for (int j = 0; j < N_CFG; j++) begin
                if (hit[j] && allow[j]) cfg_q[j] <= bus_wdata;
            end
        end
    end

    always_comb begin
        wr_drop = |(hit & ~allow);
        rd_word = '0;
        for (int j = 0; j < N_CFG; j++) begin
            if (bus_addr == ADDR_W'(j)) rd_word = cfg_q[j];
        end
    end

endmodule

// File: rtl/krw_key_bank.sv
module krw_key_bank
    import krw_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter int                DATA_W        = 32,
    parameter int                N_CFG         = 8,
    parameter int                N_SLOT        = 4,
    parameter int                RELOCK_WIN    = 4,
    parameter int                LOCK_BASE     = 16,
    parameter int                KICK_ADDR_A   = 24,
    parameter int                KICK_ADDR_B   = 25,
    parameter logic [DATA_W-1:0] SLOT_KEY_BASE = DATA_W'(DFLT_SLOT_KEY_BASE),
    parameter logic [DATA_W-1:0] KICK_KEY_A    = DATA_W'(DFLT_KICK_KEY0),
    parameter logic [DATA_W-1:0] KICK_KEY_B    = DATA_W'(DFLT_KICK_KEY1),
    parameter logic [N_CFG-1:0]  KICK_MASK     = 8'b0011_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    wr_err,
    output logic [N_CFG*DATA_W-1:0] cfg_out
);
    logic [N_SLOT-1:0] slot_open;
    logic              kick_open;
    logic              wr_drop;
    logic              err_q;

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        krw_lock_slot #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .LOCK_ADDR(LOCK_BASE + i),
            .TGT_ADDR (i),
            .KEY      (SLOT_KEY_BASE + DATA_W'(i)),
            .WIN      (RELOCK_WIN)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus_addr (bus_addr),
            .bus_wdata(bus_wdata),
            .bus_wr   (bus_wr),
            .bus_rd   (bus_rd),
            .slot_open(slot_open[i])
        );
    end

    krw_kick_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .ADDR_A(KICK_ADDR_A),
        .ADDR_B(KICK_ADDR_B),
        .KEY_A (KICK_KEY_A),
        .KEY_B (KICK_KEY_B)
    ) u_kick (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .kick_open(kick_open)
    );

    krw_cfg_bank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .N_CFG    (N_CFG),
        .N_SLOT   (N_SLOT),
        .KICK_MASK(KICK_MASK)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .slot_open(slot_open),
        .kick_open(kick_open),
        .cfg_flat (cfg_out),
        .rd_word  (bus_rdata),
        .wr_drop  (wr_drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= wr_drop;
    end

    assign wr_err = err_q;

endmodule

// File: rtl/krw_key_bank_chk.sv
module krw_key_bank_chk #(
    parameter int                ADDR_W        = 8,
    parameter int                DATA_W        = 32,
    parameter int                N_CFG         = 8,
    parameter int                N_SLOT        = 4,
    parameter int                LOCK_BASE     = 16,
    parameter logic [DATA_W-1:0] SLOT_KEY_BASE = '0,
    parameter int                KICK_IDX      = 4,
    parameter int                FREE_IDX      = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DATA_W-1:0]       bus_rdata,
    input  logic                    wr_err,
    input  logic [N_CFG*DATA_W-1:0] cfg_out,
    input  logic [N_SLOT-1:0]       slot_open,
    input  logic                    kick_open
);
    logic [DATA_W-1:0] w0, wk, wf;
    assign w0 = cfg_out[0 +: DATA_W];
    assign wk = cfg_out[KICK_IDX*DATA_W +: DATA_W];
    assign wf = cfg_out[FREE_IDX*DATA_W +: DATA_W];

    p_slot_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_open[0]) |-> $past(bus_wr && bus_addr == ADDR_W'(LOCK_BASE)
                                      && bus_wdata == SLOT_KEY_BASE));

    p_shut_slot_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && !slot_open[0]) |=> $stable(w0));

    p_shut_slot_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && !slot_open[0]) |=> wr_err);

    p_err_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(bus_wr));

    p_kick_shut_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(KICK_IDX) && !kick_open) |=> $stable(wk));

    p_free_word_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(FREE_IDX)) |=> (wf == $past(bus_wdata)));

    p_lock_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(LOCK_BASE)) |-> (bus_rdata == '0));

endmodule

bind krw_key_bank krw_key_bank_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .N_CFG        (N_CFG),
    .N_SLOT       (N_SLOT),
    .LOCK_BASE    (LOCK_BASE),
    .SLOT_KEY_BASE(SLOT_KEY_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .wr_err   (wr_err),
    .cfg_out  (cfg_out),
    .slot_open(slot_open),
    .kick_open(kick_open)
);

// File: tb/sim_krw_key_bank.sv
module sim_krw_key_bank;
    localparam logic [31:0] SK  = 32'h5EC0_1000;
    localparam logic [31:0] KA  = 32'hC0DE_0A11;
    localparam logic [31:0] KB  = 32'h0B5E_55ED;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic         wr_err;
    logic [255:0] cfg_out;

    always #4 clk = ~clk;   // 125 MHz

    krw_key_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .wr_err(wr_err), .cfg_out(cfg_out)
    );

    typedef struct {
        int          cyc;
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sbq[$];
    item_t       it;
    logic [31:0] model [8];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops items due this cycle
    always @(negedge clk) begin
        if (rst_n) begin
            while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
                it = sbq.pop_front();
                checks++;
                if (it.is_rd ? (bus_rdata !== it.exp) : (wr_err !== it.exp[0])) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag,
                             it.is_rd ? bus_rdata : {31'b0, wr_err}, it.exp);
                end
            end
        end
    end

    task automatic op(input bit w, input bit r, input logic [7:0] a,
                      input logic [31:0] d, input bit drop, input string tag);
        item_t x;
        @(posedge clk);
        #1;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        if (r) begin
            x.cyc = cyc; x.is_rd = 1'b1; x.tag = tag;
            x.exp = (a < 8) ? model[a[2:0]] : 32'h0;
            sbq.push_back(x);
        end
        x.cyc = cyc + 1; x.is_rd = 1'b0; x.tag = {tag, " (err flag)"};
        x.exp = {31'b0, drop};
        sbq.push_back(x);
        if (w && !drop && a < 8) model[a[2:0]] = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit drop,
                      input string tag);
        op(1'b1, 1'b0, a, d, drop, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        op(1'b0, 1'b1, a, 32'h0, 1'b0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) op(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        for (int j = 0; j < 8; j++) model[j] = 32'h0;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (cfg_out !== '0 || wr_err !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state actual %h/%b expected 0/0", cfg_out[31:0], wr_err);
        end
        @(posedge clk); #1; rst_n = 1'b1;

        rd(8'h00, "R1 word0 zero after reset");
        rd(8'h05, "R1 word5 zero after reset");
        // R9 free words
        wr(8'h06, 32'h1111_2222, 1'b0, "R9 free write word6");
        wr(8'h07, 32'h3333_4444, 1'b0, "R9 free write word7");
        rd(8'h06, "R9 readback word6");
        rd(8'h07, "R9 readback word7");
        // R10 write without unlock
        wr(8'h00, 32'hDEAD_0000, 1'b1, "R10 locked write dropped");
        rd(8'h00, "R10 word0 unchanged");
        // R2 back to back
        wr(8'h10, SK, 1'b0, "R2 key slot0");
        wr(8'h00, 32'hA000_0001, 1'b0, "R2 keyed write word0");
        rd(8'h00, "R2 readback word0");
        // R2 at the edge of the window
        wr(8'h11, SK + 1, 1'b0, "R2 key slot1");
        idle(3, "R2 gap");
        wr(8'h01, 32'hB000_0001, 1'b0, "R2 write on 4th cycle");
        rd(8'h01, "R2 readback word1");
        // R3 expired window
        wr(8'h12, SK + 2, 1'b0, "R3 key slot2");
        idle(4, "R3 gap");
        wr(8'h02, 32'hC000_0001, 1'b1, "R3 write on 5th cycle dropped");
        rd(8'h02, "R3 word2 unchanged");
        // R4 consume
        wr(8'h13, SK + 3, 1'b0, "R4 key slot3");
        wr(8'h03, 32'hD000_0001, 1'b0, "R4 first write");
        wr(8'h03, 32'hD000_0002, 1'b1, "R4 second write dropped");
        rd(8'h03, "R4 word3 holds first");
        // R5 relock by zero and wrong key
        wr(8'h10, SK, 1'b0, "R5 key slot0");
        wr(8'h10, 32'h0, 1'b0, "R5 zero to lock");
        wr(8'h00, 32'hF000_0001, 1'b1, "R5 write after relock dropped");
        wr(8'h10, SK ^ 32'h1, 1'b0, "R5 wrong key");
        wr(8'h00, 32'hF000_0002, 1'b1, "R5 write after wrong key dropped");
        rd(8'h00, "R5 word0 unchanged");
        // R6 cancel by other access
        wr(8'h11, SK + 1, 1'b0, "R6 key slot1");
        rd(8'h07, "R6 foreign read");
        wr(8'h01, 32'hB000_0002, 1'b1, "R6 write after cancel dropped");
        rd(8'h11, "R11 lock register reads zero");
        rd(8'h01, "R11 locked word1 readable");
        // R7 kick pair
        wr(8'h04, 32'h4444_0001, 1'b1, "R7 kick shut drop");
        wr(8'h18, KA, 1'b0, "R7 first kick key");
        wr(8'h04, 32'h4444_0002, 1'b1, "R7 one key not enough");
        wr(8'h19, KB, 1'b0, "R7 second kick key");
        wr(8'h04, 32'h4444_0003, 1'b0, "R7 kick open word4");
        wr(8'h05, 32'h5555_0003, 1'b0, "R7 kick open word5");
        wr(8'h05, 32'h5555_0004, 1'b0, "R7 kick stays open");
        rd(8'h04, "R7 readback word4");
        rd(8'h05, "R7 readback word5");
        rd(8'h18, "R11 kick register reads zero");
        rd(8'h19, "R11 kick register B reads zero");
        // R8 re-protect
        wr(8'h19, 32'h0, 1'b0, "R8 clear kick B");
        wr(8'h05, 32'h5555_0005, 1'b1, "R8 write dropped after clear B");
        wr(8'h19, KB, 1'b0, "R8 rekick B");
        wr(8'h05, 32'h5555_0006, 1'b0, "R8 write accepted again");
        wr(8'h18, 32'h0, 1'b0, "R8 clear kick A");
        wr(8'h04, 32'h4444_0007, 1'b1, "R8 write dropped after clear A");
        rd(8'h04, "R8 word4 unchanged");
        rd(8'h05, "R8 readback word5");
        idle(4, "drain");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule